// File: doc/BRIEF.md
# Multi-Format Serial Audio Port

This block is a slave-mode stereo serial audio port. An external master supplies a bit clock and a frame clock. The block samples both with its own faster system clock. On the transmit side it takes a left/right pair of parallel words and shifts them out one bit per bit clock. On the receive side it shifts in a serial stream and presents each completed left/right pair as parallel words.

A 2-bit format code selects one of four framings at run time: the one-bit-delayed stereo format (I2S), left-justified, right-justified with 24-bit words, and right-justified with 20-bit words. A polarity bit selects which bit-clock edge carries valid data. Samples are two's complement and travel MSB first.

Both parallel sides use valid/ready. Transmit has a single holding slot. `tx_ready_o` is high while that slot is empty. A held pair is copied into the shifter when the next left channel starts. If the slot is empty at that point, the frame carries zeros. Audio cannot be stalled, so receive back-pressure cannot hold the stream. While `rx_valid_o` is high and `rx_ready_i` is low, the outputs stay valid. A newer frame that completes in that state replaces the words, and valid stays high.

Top module: `sap_port`

## Requirements
- R1: With format code 00, the MSB of each word sits one bit clock after the frame-clock edge, and the left channel is carried while the frame clock is low.
- R2: With format code 01, the MSB sits in the first bit slot after the frame-clock edge, and the left channel is carried while the frame clock is high.
- R3: With format code 10, each 32-bit channel slot carries a 24-bit word whose LSB is the last slot before the next frame-clock edge. The left channel is carried while the frame clock is high.
- R4: With format code 11, each 32-bit channel slot carries the 20 least significant bits of the transmit word, LSB last. Received 20-bit words are sign-extended from bit 19 to 24 bits.
- R5: With polarity 0, data is sampled on the rising bit-clock edge and changed on the falling edge. With polarity 1, the edges are swapped.
- R6: Bit slots outside the word window are driven 0 on transmit, and their contents do not reach the received words.
- R7: Formats 00 and 01 work with 48, 64 or 128 bit clocks per frame.
- R8: `rx_valid_o` rises once per frame, after the right word's LSB. The left and right outputs come from the same frame.
- R9: While `rx_valid_o` is high and `rx_ready_i` is low, valid stays high and a later frame overwrites the words. A cycle with both high clears valid.
- R10: An accepted transmit pair drops `tx_ready_o` until the next left-channel start loads it. A frame whose start finds no pending pair transmits zeros.
- R11: After reset, `sdout_o` is 0, `rx_valid_o` is 0 and `tx_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Bit clock from the master |
| fclk_i | input | 1 | Frame clock from the master (channel select) |
| sdin_i | input | 1 | Serial receive data |
| sdout_o | output | 1 | Serial transmit data |
| fmt_i | input | 2 | Format code: 00 I2S, 01 left-justified, 10 right-justified 24, 11 right-justified 20 |
| pol_i | input | 1 | 0: data valid on rising bit-clock edge; 1: on falling edge |
| tx_l_i | input | 24 | Left transmit word |
| tx_r_i | input | 24 | Right transmit word |
| tx_valid_i | input | 1 | Transmit pair offered |
| tx_ready_o | output | 1 | Transmit holding slot empty |
| rx_l_o | output | 24 | Received left word |
| rx_r_o | output | 24 | Received right word |
| rx_valid_o | output | 1 | Received pair available |
| rx_ready_i | input | 1 | Consumer takes the received pair |

## Verification
In each format, every unused slot of the serial input is filled with ones. A design that framed the window wrongly would then pick up stray ones or shift the word by a bit, and both errors show up in the received words. The 48-clock one-bit-delayed case puts the right LSB into the next frame's first slot, which catches a design that resets its count on the raw frame-clock edge. Sign extension is exercised with both signs of bit 19. Back-pressure is tested by withholding ready across two data sets, which would expose a design that drops the newer pair or clears valid early. Draining the transmit slot exposes a design that resends stale words instead of zeros.

// File: rtl/sap_pkg.sv
package sap_pkg;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'b00,
    FMT_LJ   = 2'b01,
    FMT_RJ24 = 2'b10,
    FMT_RJ20 = 2'b11
  } sap_fmt_e;

  // Number of data bits carried per channel for a given format.
  function automatic logic [7:0] win_width(input logic [1:0] f, input int dw, input int sw);
    return (f == FMT_RJ20) ? 8'(sw) : 8'(dw);
  endfunction

  // First slot (counted from the effective channel start) that carries data.
  function automatic logic [7:0] win_offset(input logic [1:0] f, input int dw, input int sw,
                                            input int half);
    case (f)
      FMT_RJ24: return 8'(half - dw);
      FMT_RJ20: return 8'(half - sw);
      default:  return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/sap_edge_sync.sv
module sap_edge_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fclk,
  input  logic sdin,
  input  logic pol,
  output logic act_stb,
  output logic inact_stb,
  output logic fclk_s,
  output logic sdin_s
);
  logic [SYNC:0]   bclk_sh;
  logic [SYNC-1:0] fclk_sh;
  logic [SYNC-1:0] sdin_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_sh <= '0;
      fclk_sh <= '0;
      sdin_sh <= '0;
    end else begin
      bclk_sh <= {bclk_sh[SYNC-1:0], bclk};
      fclk_sh <= {fclk_sh[SYNC-2:0], fclk};
      sdin_sh <= {sdin_sh[SYNC-2:0], sdin};
    end
  end

  logic rise, fall;
  always_comb begin
    rise      = bclk_sh[SYNC-1] & ~bclk_sh[SYNC];
    fall      = ~bclk_sh[SYNC-1] & bclk_sh[SYNC];
    act_stb   = pol ? fall : rise;
    inact_stb = pol ? rise : fall;
    fclk_s    = fclk_sh[SYNC-1];
    sdin_s    = sdin_sh[SYNC-1];
  end
endmodule

// File: rtl/sap_slot_track.sv
module sap_slot_track #(
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              fclk,
  input  logic              i2s,
  output logic              tick,
  output logic [SLOT_W-1:0] slot,
  output logic              left
);
  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  logic f_d1, eff_q, eff_now;

  // The delayed format sees the frame clock one bit late and inverted, so
  // that its channel boundary lines up with its first data bit.
  always_comb eff_now = i2s ? ~f_d1 : fclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_d1  <= 1'b0;
      eff_q <= 1'b0;
      slot  <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= step;
      if (step) begin
        f_d1  <= fclk;
        eff_q <= eff_now;
        if (eff_now != eff_q) slot <= '0;
        else if (slot != SLOT_MAX) slot <= slot + 1'b1;
      end
    end
  end

  always_comb left = eff_q;
endmodule

// File: rtl/sap_rx_deser.sv
module sap_rx_deser
  import sap_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int SHORT_W = 20,
  parameter int RJ_HALF = 32,
  parameter int SLOT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [SLOT_W-1:0] slot,
  input  logic              left,
  input  logic              sd,
  input  logic [1:0]        fmt,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_l,
  output logic [DATA_W-1:0] rx_r,
  output logic              rx_valid,
  output logic              rx_done
);
  logic [DATA_W-2:0] sh;
  logic [DATA_W-1:0] sh_nx, ext, lhold;
  logic [7:0]        w, off, s8;
  logic              in_win, last;

  always_comb begin
    w      = win_width(fmt, DATA_W, SHORT_W);
    off    = win_offset(fmt, DATA_W, SHORT_W, RJ_HALF);
    s8     = 8'(slot);
    in_win = tick && (s8 >= off) && (s8 < off + w);
    last   = in_win && (s8 == off + w - 8'd1);
    sh_nx  = {sh, sd};
    ext    = (fmt == FMT_RJ20) ?
             {{(DATA_W-SHORT_W){sh_nx[SHORT_W-1]}}, sh_nx[SHORT_W-1:0]} : sh_nx;
    rx_done = last && !left;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh       <= '0;
      lhold    <= '0;
      rx_l     <= '0;
      rx_r     <= '0;
      rx_valid <= 1'b0;
    end else begin
      if (in_win) sh <= sh_nx[DATA_W-2:0];
      if (last && left) lhold <= ext;
      if (rx_done) begin
        rx_l     <= lhold;
        rx_r     <= ext;
        rx_valid <= 1'b1;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sap_tx_ser.sv
module sap_tx_ser
  import sap_pkg::*;
#(
  parameter int DATA_W  = 24,
  parameter int SHORT_W = 20,
  parameter int RJ_HALF = 32,
  parameter int SLOT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [SLOT_W-1:0] slot,
  input  logic              left,
  input  logic [1:0]        fmt,
  input  logic [DATA_W-1:0] tx_l,
  input  logic [DATA_W-1:0] tx_r,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              sd_out,
  output logic              load
);
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] hold_l, hold_r, frm_l, frm_r, src_l, src_r, cur_l, cur_r;
  logic              pending, in_win, bit_v, hs;
  logic [7:0]        w, off, s8;
  logic [IDX_W-1:0]  idx;

  always_comb begin
    w        = win_width(fmt, DATA_W, SHORT_W);
    off      = win_offset(fmt, DATA_W, SHORT_W, RJ_HALF);
    s8       = 8'(slot);
    tx_ready = !pending;
    hs       = tx_valid && !pending;
    load     = tick && (s8 == 8'd0) && left;
    src_l    = pending ? hold_l : '0;
    src_r    = pending ? hold_r : '0;
    cur_l    = load ? src_l : frm_l;
    cur_r    = load ? src_r : frm_r;
    in_win   = (s8 >= off) && (s8 < off + w);
    idx      = IDX_W'(w - 8'd1 - (s8 - off));
    bit_v    = left ? cur_l[idx] : cur_r[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_l  <= '0;
      hold_r  <= '0;
      frm_l   <= '0;
      frm_r   <= '0;
      pending <= 1'b0;
      sd_out  <= 1'b0;
    end else begin
      if (hs) begin
        hold_l  <= tx_l;
        hold_r  <= tx_r;
        pending <= 1'b1;
      end else if (load) begin
        pending <= 1'b0;
      end
      if (load) begin
        frm_l <= src_l;
        frm_r <= src_r;
      end
      if (tick) sd_out <= in_win ? bit_v : 1'b0;
    end
  end
endmodule

// File: rtl/sap_port.sv
module sap_port
  import sap_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int SHORT_W     = 20,
  parameter int RJ_HALF     = 32,
  parameter int MAX_HALF    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              fclk_i,
  input  logic              sdin_i,
  output logic              sdout_o,
  input  logic [1:0]        fmt_i,
  input  logic              pol_i,
  input  logic [DATA_W-1:0] tx_l_i,
  input  logic [DATA_W-1:0] tx_r_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] rx_l_o,
  output logic [DATA_W-1:0] rx_r_o,
  output logic              rx_valid_o,
  input  logic              rx_ready_i
);
  localparam int SLOT_W = $clog2(MAX_HALF);

  logic act_stb, inact_stb, fclk_s, sdin_s, sd_edge, i2s;
  logic rx_tick, rx_left, tx_tick, tx_left, rx_done, tx_load;
  logic [SLOT_W-1:0] rx_slot, tx_slot;

  always_comb i2s = (fmt_i == FMT_I2S);

  sap_edge_sync #(.SYNC(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk(bclk_i), .fclk(fclk_i), .sdin(sdin_i),
    .pol(pol_i), .act_stb(act_stb), .inact_stb(inact_stb),
    .fclk_s(fclk_s), .sdin_s(sdin_s)
  );

  // Receive data is captured on the valid edge, aligned with the slot tick.
  always_ff @(posedge clk) begin
    if (!rst_n) sd_edge <= 1'b0;
    else if (act_stb) sd_edge <= sdin_s;
  end

  sap_slot_track #(.SLOT_W(SLOT_W)) u_rx_trk (
    .clk(clk), .rst_n(rst_n), .step(act_stb), .fclk(fclk_s), .i2s(i2s),
    .tick(rx_tick), .slot(rx_slot), .left(rx_left)
  );

  sap_slot_track #(.SLOT_W(SLOT_W)) u_tx_trk (
    .clk(clk), .rst_n(rst_n), .step(inact_stb), .fclk(fclk_s), .i2s(i2s),
    .tick(tx_tick), .slot(tx_slot), .left(tx_left)
  );

  sap_rx_deser #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .RJ_HALF(RJ_HALF), .SLOT_W(SLOT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(rx_tick), .slot(rx_slot), .left(rx_left),
    .sd(sd_edge), .fmt(fmt_i), .rx_ready(rx_ready_i), .rx_l(rx_l_o), .rx_r(rx_r_o),
    .rx_valid(rx_valid_o), .rx_done(rx_done)
  );

  sap_tx_ser #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .RJ_HALF(RJ_HALF), .SLOT_W(SLOT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tx_tick), .slot(tx_slot), .left(tx_left),
    .fmt(fmt_i), .tx_l(tx_l_i), .tx_r(tx_r_i), .tx_valid(tx_valid_i),
    .tx_ready(tx_ready_o), .sd_out(sdout_o), .load(tx_load)
  );
endmodule

// File: rtl/sap_port_chk.sv
module sap_port_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_valid,
  input logic rx_ready,
  input logic tx_valid,
  input logic tx_ready,
  input logic sd_out,
  input logic tx_tick,
  input logic rx_done,
  input logic tx_load
);
  // R5
  sdout_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_out) |-> $past(tx_tick));

  // R8
  rx_valid_after_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(rx_done));

  // R9
  rx_valid_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> rx_valid);

  // R10
  tx_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R10
  tx_busy_until_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !tx_load) |=> !tx_ready);
endmodule

bind sap_port sap_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid_o), .rx_ready(rx_ready_i),
  .tx_valid(tx_valid_i), .tx_ready(tx_ready_o), .sd_out(sdout_o),
  .tx_tick(tx_tick), .rx_done(rx_done), .tx_load(tx_load)
);

// File: tb/sap_port_tb.sv
module sap_port_tb;
  localparam int H = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, bclk, fclk, sdin, sdout, pol, tx_valid, tx_ready, rx_valid, rx_ready;
  logic [1:0]  fmt;
  logic [23:0] tx_l, tx_r, rx_l, rx_r;

  sap_port u_dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fclk_i(fclk), .sdin_i(sdin),
    .sdout_o(sdout), .fmt_i(fmt), .pol_i(pol), .tx_l_i(tx_l), .tx_r_i(tx_r),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .rx_l_o(rx_l), .rx_r_o(rx_r),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready)
  );

  int checks = 0;
  int errors = 0;
  int hs_cnt = 0;
  logic [127:0] capb;

  always @(negedge clk) if (rst_n && rx_valid && rx_ready) hs_cnt++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  function automatic int off_of(input logic [1:0] f);
    return (f == 2'd2) ? 8 : (f == 2'd3) ? 12 : 0;
  endfunction

  function automatic int w_of(input logic [1:0] f);
    return (f == 2'd3) ? 20 : 24;
  endfunction

  function automatic string req_of(input logic [1:0] f);
    case (f)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  // One frame as master: the inactive phase changes data and frame clock,
  // the active phase is where both sides sample.
  task automatic run_frame(input logic [1:0] f, input logic p, input int bpf,
                           input logic [23:0] l, input logic [23:0] r, input bit cap);
    int n;
    n = bpf / 2;
    for (int q = 0; q < bpf; q++) begin
      int pe, s, off, w;
      logic [23:0] wd;
      logic b;
      pe  = (f == 2'd0) ? (q + bpf - 1) % bpf : q;
      s   = pe % n;
      off = off_of(f);
      w   = w_of(f);
      wd  = (pe < n) ? l : r;
      b   = (s >= off && s < off + w) ? wd[w - 1 - (s - off)] : 1'b1;
      @(negedge clk);
      bclk = p;
      fclk = (q < n) ? (f != 2'd0) : (f == 2'd0);
      sdin = b;
      repeat (H) @(negedge clk);
      if (cap) capb[pe] = sdout;
      bclk = ~p;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic decode(input logic [1:0] f, input int bpf,
                        output logic [23:0] vl, output logic [23:0] vr, output int ones);
    int n, off, w;
    n = bpf / 2; off = off_of(f); w = w_of(f);
    vl = '0; vr = '0; ones = 0;
    for (int k = 0; k < w; k++) begin
      vl = {vl[22:0], capb[off + k]};
      vr = {vr[22:0], capb[n + off + k]};
    end
    for (int pp = 0; pp < bpf; pp++) begin
      int s;
      s = pp % n;
      if ((s < off || s >= off + w) && capb[pp]) ones++;
    end
  endtask

  // {fmt, pol, bits per frame, left, right}
  localparam logic [58:0] VEC [8] = '{
    {2'd0, 1'b0, 8'd64,  24'hA5C3F1, 24'h1E2D3C},  // R1 R5
    {2'd0, 1'b1, 8'd48,  24'h800001, 24'h7FFFFE},  // R1 R5 R7
    {2'd1, 1'b0, 8'd128, 24'h123456, 24'hFEDCBA},  // R2 R7
    {2'd1, 1'b1, 8'd48,  24'hFFFFFF, 24'h000001},  // R2 R5 R7
    {2'd2, 1'b0, 8'd64,  24'hC0FFEE, 24'h0BEEF0},  // R3
    {2'd2, 1'b1, 8'd64,  24'h7F00FF, 24'h80FF00},  // R3 R5
    {2'd3, 1'b0, 8'd64,  24'h0ABCDE, 24'h012345},  // R4 negative and positive
    {2'd3, 1'b1, 8'd64,  24'hF54321, 24'hFA5A5A}   // R4 R5
  };

  initial begin
    logic [23:0] vl, vr, el, er;
    int ones, h0;
    rst_n = 1'b0; bclk = 1'b0; fclk = 1'b0; sdin = 1'b0; fmt = 2'd1; pol = 1'b0;
    tx_l = '0; tx_r = '0; tx_valid = 1'b0; rx_ready = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 sdout after reset", 32'(sdout), 32'd0);
    check("R11 rx_valid after reset", 32'(rx_valid), 32'd0);
    check("R11 tx_ready after reset", 32'(tx_ready), 32'd1);

    rx_ready = 1'b1;
    tx_valid = 1'b1;
    for (int i = 0; i < 8; i++) begin
      logic [1:0] f; logic p; int bpf; logic [23:0] l, r;
      {f, p, bpf[7:0], l, r} = VEC[i];
      bpf[31:8] = '0;
      fmt = f; pol = p; tx_l = l; tx_r = r;
      run_frame(f, p, bpf, l, r, 1'b0);
      run_frame(f, p, bpf, l, r, 1'b0);
      h0 = hs_cnt;
      run_frame(f, p, bpf, l, r, 1'b1);
      check("R8 one rx pair per frame", 32'(hs_cnt - h0), 32'd1);
      run_frame(f, p, bpf, l, r, 1'b0);
      repeat (4) @(negedge clk);
      decode(f, bpf, vl, vr, ones);
      el = (f == 2'd3) ? {4'h0, l[19:0]} : l;
      er = (f == 2'd3) ? {4'h0, r[19:0]} : r;
      check({req_of(f), " tx left"}, 32'(vl), 32'(el));
      check({req_of(f), " tx right"}, 32'(vr), 32'(er));
      check("R6 tx unused slots zero", 32'(ones), 32'd0);
      el = (f == 2'd3) ? {{4{l[19]}}, l[19:0]} : l;
      er = (f == 2'd3) ? {{4{r[19]}}, r[19:0]} : r;
      check({req_of(f), " R6 rx left"}, 32'(rx_l), 32'(el));
      check({req_of(f), " R6 rx right"}, 32'(rx_r), 32'(er));
    end

    // R10: drain the holding slot, then frames carry zeros.
    tx_valid = 1'b0;
    fmt = 2'd1; pol = 1'b0;
    run_frame(2'd1, 1'b0, 64, 24'h0F0F0F, 24'hF0F0F0, 1'b0);
    run_frame(2'd1, 1'b0, 64, 24'h0F0F0F, 24'hF0F0F0, 1'b0);
    check("R10 tx_ready after load", 32'(tx_ready), 32'd1);
    run_frame(2'd1, 1'b0, 64, 24'h0F0F0F, 24'hF0F0F0, 1'b1);
    decode(2'd1, 64, vl, vr, ones);
    check("R10 empty slot left zero", 32'(vl), 32'd0);
    check("R10 empty slot right zero", 32'(vr), 32'd0);

    // R10: accept with the bit clock idle, ready stays low.
    tx_l = 24'hABCDEF; tx_r = 24'h135790; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    check("R10 ready low after accept", 32'(tx_ready), 32'd0);
    repeat (20) @(negedge clk);
    check("R10 ready low until load", 32'(tx_ready), 32'd0);

    // R9: back-pressure keeps valid and takes the newest pair.
    rx_ready = 1'b0;
    for (int k = 0; k < 3; k++) run_frame(2'd1, 1'b0, 64, 24'h111111, 24'h222222, 1'b0);
    check("R9 valid held", 32'(rx_valid), 32'd1);
    check("R9 left held", 32'(rx_l), 32'h111111);
    check("R9 right held", 32'(rx_r), 32'h222222);
    for (int k = 0; k < 3; k++) run_frame(2'd1, 1'b0, 64, 24'h333333, 24'h444444, 1'b0);
    check("R9 valid still held", 32'(rx_valid), 32'd1);
    check("R9 left overwritten", 32'(rx_l), 32'h333333);
    check("R9 right overwritten", 32'(rx_r), 32'h444444);
    rx_ready = 1'b1;
    @(negedge clk);
    check("R9 valid cleared by ready", 32'(rx_valid), 32'd0);

    finish_run();
  end
endmodule